// File: doc/BRIEF.md
# Byte-to-Serial Transmit Serializer

The block converts a stream of bytes into one serial bit stream for the transmit side of a synchronous optical line. Everything except the input holding register runs on the serial bit clock. A free-running divide-by-eight timing generator produces a byte-rate clock, `byteClkOut`, that upstream framing and overhead logic can use as its own clock. The same generator makes an internal load strobe. The strobe copies the most recently captured byte into a parallel-load shift register, and that register then sends the byte out one bit per serial clock, most significant bit first.

Bytes enter through a holding register on a separate input clock, `byteInClk`. The normal connection ties `byteInClk` to `byteClkOut`. The load strobe sits several serial clocks after the rising edge of the byte clock, so the captured byte is always settled before it is transferred. The input clock may also come from elsewhere, provided it is frequency-locked to the serial clock and rises early enough in the byte period. There is no external load pin: the shift register takes parallel data only from the holding register, and only when the internal strobe fires.

Top module: `tx_byte_serializer`

## Requirements
- R1: On every rising edge of `byteInClk` (while `rst` is low), the holding register takes in `dataIn`. The byte captured at the k-th rising edge after reset (k = 0, 1, ...) is the k-th byte sent on `serOut`.
- R2: After reset is released, `byteClkOut` rises on the first serial clock edge. From then on it repeats a period of 8 serial clocks: high for 4, then low for 4.
- R3: The load strobe is internal and lasts exactly one serial clock, once every 8 serial clocks. Serial edges after reset are counted E1, E2, ..., where E1 is the edge on which `byteClkOut` rises. The load takes effect on edge E(LOAD_PHASE+1+8k), with LOAD_PHASE = 3 by default. That is LOAD_PHASE serial clocks after each rising edge of the byte clock.
- R4: Cycle n is the interval that follows edge En. For n ≥ 4, `serOut` carries bit (7 − j) of byte k, where k = (n − 4) / 8 and j = (n − 4) mod 8. Bit 7 therefore appears in the cycle right after the load, and the stream has no gaps between bytes.
- R5: With `byteInClk` tied to `byteClkOut`, every byte captured on a rising edge of the byte clock is sent unchanged, for any data value including 0x00, 0xFF and single-bit patterns.
- R6: With `byteInClk` driven by a separate clock that is frequency-locked to the serial clock and rises half a serial clock after `byteClkOut`, the serial stream matches R4 exactly.
- R7: While `rst` is high at a serial clock edge, `serOut` and `byteClkOut` are low after that edge. The divider counter returns to zero and the shift register clears. As a result, `serOut` stays low in cycles 1 to 3 after release.
- R8: Asserting `rst` in the middle of a byte drives `serOut` and `byteClkOut` low on the next serial clock edge, abandoning the rest of that byte. After release, timing restarts from E1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| serialClk | input | 1 | Serial bit clock; clocks the divider and the shift register |
| rst | input | 1 | Synchronous active-high reset |
| byteInClk | input | 1 | Clock of the input holding register; frequency-locked to serialClk |
| dataIn | input | 8 | Parallel byte to be sent |
| byteClkOut | output | 1 | Byte-rate clock, one eighth of serialClk, 4 high and 4 low |
| serOut | output | 1 | Serial data, most significant bit first |

## Verification
A counter that skips or repeats a state shows up at the ports within one byte period. `byteClkOut` would break its 4-high and 4-low rhythm, and the serial stream would slip by a bit against the expected cycle positions. A load at the wrong phase, or a wrong shift direction, misplaces bits in the first byte sent, within 12 serial clocks of reset. A holding register that captures on the wrong edge, or a reset that fails to clear the shift register, shows up as wrong values in the first few serial cycles after release. The same faults are also checked with the input clock skewed half a serial clock behind the byte clock.

// File: rtl/txser_pkg.sv
package txser_pkg;

  localparam int unsigned DEF_WIDTH      = 8;
  localparam int unsigned DEF_LOAD_PHASE = 3;

  typedef struct packed {
    logic load;
    logic shift;
  } ctrl_t;

endpackage

// File: rtl/txser_timing.sv
module txser_timing
  import txser_pkg::*;
#(
  parameter int unsigned WIDTH      = DEF_WIDTH,
  parameter int unsigned LOAD_PHASE = DEF_LOAD_PHASE
) (
  input  logic  serialClk,
  input  logic  rst,
  output logic  byteClk,
  output ctrl_t ctrl
);

  localparam int unsigned CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int unsigned HALF  = WIDTH / 2;
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(WIDTH - 1);
  localparam logic [CNT_W-1:0] HALF_CNT  = CNT_W'(HALF);
  localparam logic [CNT_W-1:0] LOAD_CNT  = CNT_W'(LOAD_PHASE);

  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] phaseNext;
  logic             byteClkQ;

  always_comb begin
    if (phaseCnt == LAST_CNT) begin
      phaseNext = '0;
    end else begin
      phaseNext = phaseCnt + 1'b1;
    end
  end

  always_ff @(posedge serialClk) begin
    if (rst) begin
      phaseCnt <= '0;
      byteClkQ <= 1'b0;
    end else begin
      phaseCnt <= phaseNext;
      byteClkQ <= (phaseCnt < HALF_CNT);
    end
  end

  always_comb begin
    ctrl.load  = !rst && (phaseCnt == LOAD_CNT);
    ctrl.shift = !rst && (phaseCnt != LOAD_CNT);
  end

  assign byteClk = byteClkQ;

endmodule

// File: rtl/txser_datapath.sv
module txser_datapath
  import txser_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             serialClk,
  input  logic             byteInClk,
  input  logic             rst,
  input  logic [WIDTH-1:0] dataIn,
  input  ctrl_t            ctrl,
  output logic [WIDTH-1:0] holdQ,
  output logic             serOut
);

  logic [WIDTH-1:0] shiftQ;
  logic [WIDTH-1:0] shiftNext;

  always_ff @(posedge byteInClk) begin
    if (rst) begin
      holdQ <= '0;
    end else begin
      holdQ <= dataIn;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : gCell
    logic fromBelow;
    if (i == 0) begin : gFill
      assign fromBelow = 1'b0;
    end else begin : gChain
      assign fromBelow = shiftQ[i-1];
    end
    always_comb begin
      if (ctrl.load) begin
        shiftNext[i] = holdQ[i];
      end else if (ctrl.shift) begin
        shiftNext[i] = fromBelow;
      end else begin
        shiftNext[i] = shiftQ[i];
      end
    end
  end

  always_ff @(posedge serialClk) begin
    if (rst) begin
      shiftQ <= '0;
    end else begin
      shiftQ <= shiftNext;
    end
  end

  assign serOut = shiftQ[WIDTH-1];

endmodule

// File: rtl/tx_byte_serializer.sv
module tx_byte_serializer
  import txser_pkg::*;
#(
  parameter int unsigned WIDTH      = DEF_WIDTH,
  parameter int unsigned LOAD_PHASE = DEF_LOAD_PHASE
) (
  input  logic             serialClk,
  input  logic             rst,
  input  logic             byteInClk,
  input  logic [WIDTH-1:0] dataIn,
  output logic             byteClkOut,
  output logic             serOut
);

  ctrl_t            ctrlBus;
  logic [WIDTH-1:0] holdQ;

  txser_timing #(
    .WIDTH      (WIDTH),
    .LOAD_PHASE (LOAD_PHASE)
  ) u_timing (
    .serialClk (serialClk),
    .rst       (rst),
    .byteClk   (byteClkOut),
    .ctrl      (ctrlBus)
  );

  txser_datapath #(
    .WIDTH (WIDTH)
  ) u_datapath (
    .serialClk (serialClk),
    .byteInClk (byteInClk),
    .rst       (rst),
    .dataIn    (dataIn),
    .ctrl      (ctrlBus),
    .holdQ     (holdQ),
    .serOut    (serOut)
  );

endmodule

// File: rtl/tx_byte_serializer_checker.sv
module tx_byte_serializer_checker #(
  parameter int unsigned WIDTH      = 8,
  parameter int unsigned LOAD_PHASE = 3
) (
  input logic serialClk,
  input logic rst,
  input logic byteClkOut,
  input logic serOut,
  input logic load,
  input logic holdMsb
);

  localparam logic [3:0] HALF_LEN  = 4'(WIDTH / 2);
  localparam logic [3:0] LOAD_AGE  = 4'(LOAD_PHASE - 1);

  logic       prevClk;
  logic       seenFall;
  logic [3:0] runLen;
  logic [3:0] riseAge;

  always_ff @(posedge serialClk) begin
    if (rst) begin
      prevClk  <= 1'b0;
      seenFall <= 1'b0;
      runLen   <= '0;
      riseAge  <= '0;
    end else begin
      prevClk <= byteClkOut;
      if (prevClk && !byteClkOut) begin
        seenFall <= 1'b1;
      end
      if (byteClkOut != prevClk) begin
        runLen <= 4'd1;
      end else if (runLen != 4'hF) begin
        runLen <= runLen + 4'd1;
      end
      if (byteClkOut && !prevClk) begin
        riseAge <= 4'd1;
      end else if (riseAge != 4'hF) begin
        riseAge <= riseAge + 4'd1;
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge serialClk) disable iff (rst)
    $fell(rst) |-> (!serOut && !byteClkOut)); // R7

  AST_CLK_HIGH_RUN: assert property (@(posedge serialClk) disable iff (rst)
    ($fell(byteClkOut) && !$past(rst)) |-> (runLen == HALF_LEN)); // R2

  AST_CLK_LOW_RUN: assert property (@(posedge serialClk) disable iff (rst)
    ($rose(byteClkOut) && seenFall) |-> (runLen == HALF_LEN)); // R2

  AST_LOAD_SINGLE: assert property (@(posedge serialClk) disable iff (rst)
    load |=> !load); // R3

  AST_LOAD_PHASE: assert property (@(posedge serialClk) disable iff (rst)
    load |-> (riseAge == LOAD_AGE)); // R3

  AST_LOAD_MSB: assert property (@(posedge serialClk) disable iff (rst)
    load |=> (serOut == $past(holdMsb))); // R4

endmodule

bind tx_byte_serializer tx_byte_serializer_checker #(
  .WIDTH      (WIDTH),
  .LOAD_PHASE (LOAD_PHASE)
) u_checker (
  .serialClk  (serialClk),
  .rst        (rst),
  .byteClkOut (byteClkOut),
  .serOut     (serOut),
  .load       (ctrlBus.load),
  .holdMsb    (holdQ[WIDTH-1])
);

// File: tb/test_tx_byte_serializer.sv
`timescale 1ns/1ps
module test_tx_byte_serializer;

  logic       serialClk = 1'b0;
  logic       rst       = 1'b1;
  logic [7:0] dataIn    = 8'h00;
  logic       byteClkOut;
  logic       serOut;
  logic       skewClk   = 1'b0;
  logic       useSkew   = 1'b0;
  wire        byteInClk = useSkew ? skewClk : byteClkOut;

  logic [7:0] byteMem [64];
  int         capIdx    = 0;
  int         baseIdx   = 0;
  int         edgeCount = 0;
  bit         checking  = 1'b0;
  bit         midReset  = 1'b0;
  bit         done      = 1'b0;
  int         total     = 0;
  int         fails     = 0;

  tx_byte_serializer i_tx_byte_serializer (
    .serialClk  (serialClk),
    .rst        (rst),
    .byteInClk  (byteInClk),
    .dataIn     (dataIn),
    .byteClkOut (byteClkOut),
    .serOut     (serOut)
  );

  always #4 serialClk = ~serialClk;

  always @(negedge serialClk) skewClk <= byteClkOut;

  always @(posedge serialClk) begin
    if (rst) edgeCount <= 0;
    else     edgeCount <= edgeCount + 1;
  end

  always @(posedge byteInClk) begin
    #1;
    capIdx = capIdx + 1;
    dataIn = byteMem[(baseIdx + capIdx) % 64];
  end

  function automatic logic expClk(int n);
    if (n == 0) return 1'b0;
    return (((n - 1) % 8) < 4);
  endfunction

  function automatic logic expBit(int n);
    int k;
    int j;
    if (n < 4) return 1'b0;
    k = (n - 4) / 8;
    j = (n - 4) % 8;
    return byteMem[(baseIdx + k) % 64][7 - j];
  endfunction

  task automatic check(string tag, logic act, logic exp, int n);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, n, act, exp);
    end
  endtask

  always @(negedge serialClk) begin
    if (checking && !done) begin
      string dtag;
      if (edgeCount == 0)      dtag = midReset ? "R8 reset abort" : "R7 reset";
      else if (edgeCount < 4)  dtag = "R7 cleared shift";
      else if (useSkew)        dtag = "R4/R6/R1 skewed clock stream";
      else                     dtag = "R4/R3/R5/R1 tied clock stream";
      check(dtag, serOut, expBit(edgeCount), edgeCount);
      check((edgeCount == 0) ? (midReset ? "R8 byte clock" : "R7 byte clock") : "R2 byte clock",
            byteClkOut, expClk(edgeCount), edgeCount);
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    byteMem[0] = 8'h80;
    byteMem[1] = 8'h01;
    byteMem[2] = 8'hFF;
    byteMem[3] = 8'h00;
    byteMem[4] = 8'hA5;
    byteMem[5] = 8'h5A;
    for (int i = 6; i < 64; i++) byteMem[i] = 8'($urandom);
    byteMem[32] = 8'h01;
    byteMem[33] = 8'hFE;
    dataIn  = byteMem[0];
    capIdx  = 0;
    baseIdx = 0;
    repeat (3) @(posedge serialClk);
    @(negedge serialClk);
    checking = 1'b1;
    @(negedge serialClk);
    rst = 1'b0;
    repeat (330) @(negedge serialClk);
    midReset = 1'b1;
    rst = 1'b1;
    repeat (3) @(negedge serialClk);
    useSkew = 1'b1;
    baseIdx = 32;
    capIdx  = 0;
    dataIn  = byteMem[32];
    rst = 1'b0;
    repeat (250) @(negedge serialClk);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule